// File: doc/BRIEF.md
# Row Command Spacing Checker

This block watches the row commands (activate and precharge) that a controller places on a channel shared by several DRAM devices, each holding a row of banks. Every command names a device, a bank and a row. The checker remembers when recent commands were issued and judges each new one against three minimum spacings. It produces one result per command, one cycle later. The result shows either a legal command or a violation, with a code that names the rule that was broken.

The spacing rules depend on how the new command relates to earlier ones. Any two consecutive commands on the channel must be at least the short packet spacing apart, whatever device they go to. Two commands of the same kind sent to the same device need a longer same-kind spacing. A command that goes to the same bank, or to a neighbouring bank, of a device that recently saw a command needs the bank spacing. A precharge followed by an activate to a non-neighbouring bank of the same device needs only the packet spacing. The three spacings are cycle counts. They are captured from configuration inputs while reset is held.

Top module: `rcsc_top`

## Requirements
- R1: For a command in cycle t, `res_valid` is high in cycle t+1, and `res_dev` and `res_row` carry that command's device and row. `res_valid` is low in the cycle after any cycle with no command.
- R2: While `rst_n` is low, the three spacing inputs are captured. All command history is forgotten and all result outputs are driven low.
- R3: A command that arrives fewer than `cfg_pkt_gap` cycles after the previous command on the channel, to any device, is flagged with reason 1 (spacing).
- R4: A command that arrives fewer than `cfg_same_gap` cycles after the latest command of the same kind to the same device is flagged with reason 3 (same kind).
- R5: A command is flagged with reason 2 (bank) when it arrives fewer than `cfg_bank_gap` cycles after the latest precharge, or the latest activate, to the same device whose bank index is equal to its own or differs from it by one. Bank 0 and the highest bank are not neighbours.
- R6: Commands to different devices are subject only to the packet spacing. So is a precharge followed by an activate to a non-neighbouring bank of the same device.
- R7: Reason codes are 0 for legal, 1 for spacing, 2 for bank and 3 for same kind. When several rules are broken, same kind wins over bank, and bank wins over spacing. `res_err` is high exactly when the reason is nonzero.
- R8: Spacing is counted in clock cycles between the two commands. A spacing equal to the programmed minimum is legal. The count saturates, so a long idle period never makes an old command look recent again.
- R9: A violating command still becomes the latest command of its kind for its device and for the channel. `res_err` is a single-cycle pulse for each offending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; spacing inputs are captured while it is low |
| cfg_pkt_gap | input | GAP_W | Minimum cycles between any two row commands |
| cfg_same_gap | input | GAP_W | Minimum cycles between same-kind commands to one device |
| cfg_bank_gap | input | GAP_W | Minimum cycles for same or neighbouring bank of one device |
| cmd_valid | input | 1 | A row command is present this cycle |
| cmd_act | input | 1 | 1 = activate, 0 = precharge |
| cmd_dev | input | DEV_W | Target device |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row address |
| res_valid | output | 1 | A result for the previous cycle's command |
| res_err | output | 1 | That command broke a spacing rule |
| res_reason | output | 2 | Reason code (see R7) |
| res_dev | output | DEV_W | Device of the judged command |
| res_row | output | ROW_W | Row of the judged command |

## Verification
The main stimulus is a stream of commands that varies four things: the device relation, the command kind, the bank distance (equal, off by one, far, and the two ends of the bank range) and the spacing. The spacing is set to one below each minimum and to exactly the minimum. The stream separates the three reason codes from one another. Cases where two rules fail at once check the priority, and a command that is judged after a violating one shows that violations are still recorded. A second configuration checks two more things: that a reset clears history, and that the spacings are reloaded. Its long idle stretch, longer than the counter range, followed by a short same-kind repeat, separates saturation from wraparound.

// File: rtl/rcsc_pkg.sv
`timescale 1ns/1ps
package rcsc_pkg;
    typedef enum logic [1:0] {
        RSN_NONE      = 2'd0,
        RSN_SPACING   = 2'd1,
        RSN_BANK      = 2'd2,
        RSN_SAME_KIND = 2'd3
    } reason_e;
endpackage

// File: rtl/rcsc_rec.sv
`timescale 1ns/1ps
// One history slot: whether it holds a command, that command's bank,
// and a saturating count of cycles since it was recorded.
module rcsc_rec #(
    parameter int BANK_W = 4,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] bank_i,
    output logic              vld_o,
    output logic [GAP_W-1:0]  age_o,
    output logic [BANK_W-1:0] bank_o
);
    typedef struct packed {
        logic              vld;
        logic [GAP_W-1:0]  age;
        logic [BANK_W-1:0] bank;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load) begin
            slot_d.vld  = 1'b1;
            slot_d.age  = GAP_W'(1);
            slot_d.bank = bank_i;
        end else if (slot_q.age != '1) begin
            slot_d.age = slot_q.age + GAP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign vld_o  = slot_q.vld;
    assign age_o  = slot_q.age;
    assign bank_o = slot_q.bank;
endmodule

// File: rtl/rcsc_judge.sv
`timescale 1ns/1ps
// Combinational rule evaluation for one incoming command against the
// history of its device and of the channel.
module rcsc_judge
    import rcsc_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int GAP_W  = 8
) (
    input  logic              is_act,
    input  logic [BANK_W-1:0] bank,
    input  logic              pre_vld,
    input  logic [GAP_W-1:0]  pre_age,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              act_vld,
    input  logic [GAP_W-1:0]  act_age,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              any_vld,
    input  logic [GAP_W-1:0]  any_age,
    input  logic [GAP_W-1:0]  gap_pkt,
    input  logic [GAP_W-1:0]  gap_same,
    input  logic [GAP_W-1:0]  gap_bank,
    output reason_e           reason
);
    function automatic logic near(input logic [BANK_W-1:0] a, input logic [BANK_W-1:0] b);
        logic [BANK_W:0] ax, bx;
        ax = {1'b0, a};
        bx = {1'b0, b};
        return (ax == bx) || (ax + 1'b1 == bx) || (bx + 1'b1 == ax);
    endfunction

    logic same_hit, bank_hit, pkt_hit;

    always_comb begin
        same_hit = is_act ? (act_vld && (act_age < gap_same))
                          : (pre_vld && (pre_age < gap_same));
        bank_hit = (pre_vld && near(bank, pre_bank) && (pre_age < gap_bank)) ||
                   (act_vld && near(bank, act_bank) && (act_age < gap_bank));
        pkt_hit  = any_vld && (any_age < gap_pkt);
        if (same_hit)      reason = RSN_SAME_KIND;
        else if (bank_hit) reason = RSN_BANK;
        else if (pkt_hit)  reason = RSN_SPACING;
        else               reason = RSN_NONE;
    end
endmodule

// File: rtl/rcsc_top.sv
`timescale 1ns/1ps
module rcsc_top
    import rcsc_pkg::*;
#(
    parameter int DEVICES = 4,
    parameter int BANKS   = 16,
    parameter int ROW_W   = 9,
    parameter int GAP_W   = 8,
    localparam int DEV_W  = $clog2(DEVICES),
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAP_W-1:0]  cfg_pkt_gap,
    input  logic [GAP_W-1:0]  cfg_same_gap,
    input  logic [GAP_W-1:0]  cfg_bank_gap,
    input  logic              cmd_valid,
    input  logic              cmd_act,
    input  logic [DEV_W-1:0]  cmd_dev,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    output logic              res_valid,
    output logic              res_err,
    output logic [1:0]        res_reason,
    output logic [DEV_W-1:0]  res_dev,
    output logic [ROW_W-1:0]  res_row
);
    typedef struct packed {
        logic [GAP_W-1:0] gap_pkt;
        logic [GAP_W-1:0] gap_same;
        logic [GAP_W-1:0] gap_bank;
        logic             valid;
        logic             err;
        reason_e          reason;
        logic [DEV_W-1:0] dev;
        logic [ROW_W-1:0] row;
    } state_t;

    state_t st_d, st_q;

    logic              pre_vld  [DEVICES];
    logic [GAP_W-1:0]  pre_age  [DEVICES];
    logic [BANK_W-1:0] pre_bank [DEVICES];
    logic              act_vld  [DEVICES];
    logic [GAP_W-1:0]  act_age  [DEVICES];
    logic [BANK_W-1:0] act_bank [DEVICES];
    logic              any_vld;
    logic [GAP_W-1:0]  any_age;
    logic [BANK_W-1:0] any_bank;

    for (genvar g = 0; g < DEVICES; g++) begin : g_dev
        logic hit;
        assign hit = cmd_valid && (cmd_dev == DEV_W'(g));

        rcsc_rec #(.BANK_W(BANK_W), .GAP_W(GAP_W)) u_pre (
            .clk(clk), .rst_n(rst_n), .load(hit && !cmd_act), .bank_i(cmd_bank),
            .vld_o(pre_vld[g]), .age_o(pre_age[g]), .bank_o(pre_bank[g])
        );
        rcsc_rec #(.BANK_W(BANK_W), .GAP_W(GAP_W)) u_act (
            .clk(clk), .rst_n(rst_n), .load(hit && cmd_act), .bank_i(cmd_bank),
            .vld_o(act_vld[g]), .age_o(act_age[g]), .bank_o(act_bank[g])
        );
    end

    rcsc_rec #(.BANK_W(BANK_W), .GAP_W(GAP_W)) u_any (
        .clk(clk), .rst_n(rst_n), .load(cmd_valid), .bank_i(cmd_bank),
        .vld_o(any_vld), .age_o(any_age), .bank_o(any_bank)
    );

    reason_e verdict;

    rcsc_judge #(.BANK_W(BANK_W), .GAP_W(GAP_W)) u_judge (
        .is_act  (cmd_act),
        .bank    (cmd_bank),
        .pre_vld (pre_vld[cmd_dev]),
        .pre_age (pre_age[cmd_dev]),
        .pre_bank(pre_bank[cmd_dev]),
        .act_vld (act_vld[cmd_dev]),
        .act_age (act_age[cmd_dev]),
        .act_bank(act_bank[cmd_dev]),
        .any_vld (any_vld),
        .any_age (any_age),
        .gap_pkt (st_q.gap_pkt),
        .gap_same(st_q.gap_same),
        .gap_bank(st_q.gap_bank),
        .reason  (verdict)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = cmd_valid;
        st_d.err    = cmd_valid && (verdict != RSN_NONE);
        st_d.reason = cmd_valid ? verdict : RSN_NONE;
        if (cmd_valid) begin
            st_d.dev = cmd_dev;
            st_d.row = cmd_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.gap_pkt  <= cfg_pkt_gap;
            st_q.gap_same <= cfg_same_gap;
            st_q.gap_bank <= cfg_bank_gap;
        end else begin
            st_q <= st_d;
        end
    end

    // Bank of the last channel command is kept for the slot's uniform shape only.
    logic unused_bank;
    assign unused_bank = ^any_bank;

    logic [GAP_W-1:0] gap_same_q;
    assign gap_same_q = st_q.gap_same;

    assign res_valid  = st_q.valid;
    assign res_err    = st_q.err;
    assign res_reason = st_q.reason;
    assign res_dev    = st_q.dev;
    assign res_row    = st_q.row;
endmodule

// File: rtl/rcsc_chk.sv
`timescale 1ns/1ps
module rcsc_chk #(
    parameter int DEV_W = 2,
    parameter int ROW_W = 9,
    parameter int GAP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_act,
    input logic [DEV_W-1:0] cmd_dev,
    input logic [ROW_W-1:0] cmd_row,
    input logic             res_valid,
    input logic             res_err,
    input logic [1:0]       res_reason,
    input logic [DEV_W-1:0] res_dev,
    input logic [ROW_W-1:0] res_row,
    input logic [GAP_W-1:0] gap_same
);
    AST_RESULT_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> res_valid); // R1

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !res_valid); // R1

    AST_ECHO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (res_dev == $past(cmd_dev) && res_row == $past(cmd_row))); // R1

    AST_ERR_MATCHES_REASON: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_err == (res_reason != 2'd0))); // R7

    AST_ERR_NEEDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> res_valid); // R9

    AST_SAME_KIND_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmd_valid) && cmd_valid && cmd_dev == $past(cmd_dev) &&
         cmd_act == $past(cmd_act) && gap_same >= GAP_W'(2))
        |=> (res_err && res_reason == 2'd3)); // R4
endmodule

bind rcsc_top rcsc_chk #(.DEV_W(DEV_W), .ROW_W(ROW_W), .GAP_W(GAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_act(cmd_act),
    .cmd_dev(cmd_dev), .cmd_row(cmd_row), .res_valid(res_valid), .res_err(res_err),
    .res_reason(res_reason), .res_dev(res_dev), .res_row(res_row), .gap_same(gap_same_q)
);

// File: tb/tb_rcsc_top.sv
`timescale 1ns/1ps
module tb_rcsc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_pkt_gap, cfg_same_gap, cfg_bank_gap;
    logic       cmd_valid = 1'b0;
    logic       cmd_act = 1'b0;
    logic [1:0] cmd_dev = '0;
    logic [3:0] cmd_bank = '0;
    logic [8:0] cmd_row = '0;
    logic       res_valid, res_err;
    logic [1:0] res_reason;
    logic [1:0] res_dev;
    logic [8:0] res_row;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rcsc_top dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_pkt_gap(cfg_pkt_gap), .cfg_same_gap(cfg_same_gap), .cfg_bank_gap(cfg_bank_gap),
        .cmd_valid(cmd_valid), .cmd_act(cmd_act), .cmd_dev(cmd_dev),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .res_valid(res_valid), .res_err(res_err), .res_reason(res_reason),
        .res_dev(res_dev), .res_row(res_row)
    );

    // wait = cycles since previous command; reason codes per R7
    typedef struct packed {
        logic [8:0] wait_c;
        logic       act;
        logic [1:0] dev;
        logic [3:0] bank;
        logic [1:0] rsn;
    } vec_t;

    // gaps: packet 2, same kind 6, bank 4
    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{9'd1, 1'b0, 2'd0, 4'd0,  2'd0},  // first command, clean history   R6
        '{9'd1, 1'b1, 2'd1, 4'd0,  2'd1},  // other device, 1 cycle          R3
        '{9'd2, 1'b1, 2'd0, 4'd5,  2'd0},  // pre->act far bank, same dev    R6
        '{9'd2, 1'b0, 2'd0, 4'd9,  2'd3},  // pre after pre 5 cycles         R4
        '{9'd6, 1'b1, 2'd0, 4'd10, 2'd0},  // neighbour at bank gap or more  R5
        '{9'd2, 1'b0, 2'd0, 4'd11, 2'd2},  // neighbour of act, 2 cycles     R5
        '{9'd7, 1'b0, 2'd2, 4'd3,  2'd0},  // quiet device                   R6
        '{9'd2, 1'b1, 2'd2, 4'd3,  2'd2},  // same bank, 2 cycles            R5
        '{9'd3, 1'b1, 2'd2, 4'd7,  2'd3},  // act after violating act        R9
        '{9'd2, 1'b1, 2'd2, 4'd8,  2'd3},  // same kind and neighbour        R7
        '{9'd1, 1'b0, 2'd3, 4'd8,  2'd1},  // other device, 1 cycle          R3
        '{9'd5, 1'b0, 2'd2, 4'd0,  2'd0},  // far bank from last act         R6
        '{9'd2, 1'b1, 2'd2, 4'd1,  2'd2},  // neighbour of pre, 2 cycles     R5
        '{9'd5, 1'b1, 2'd1, 4'd15, 2'd0},  // long after                     R6
        '{9'd4, 1'b0, 2'd1, 4'd14, 2'd0},  // neighbour exactly at bank gap  R8
        '{9'd3, 1'b0, 2'd3, 4'd15, 2'd0},  // highest bank                   R6
        '{9'd3, 1'b1, 2'd3, 4'd0,  2'd0},  // bank 0 is no neighbour of 15   R5
        '{9'd6, 1'b1, 2'd3, 4'd4,  2'd0},  // same kind exactly at gap       R8
        '{9'd5, 1'b1, 2'd3, 4'd8,  2'd3}   // same kind one below gap        R4
    };

    function automatic string tag_of(input logic [1:0] r);
        case (r)
            2'd3:    return "R4";
            2'd2:    return "R5";
            2'd1:    return "R3";
            default: return "R6";
        endcase
    endfunction

    task automatic run_cmd(input int w, input logic act, input logic [1:0] dev,
                           input logic [3:0] bank, input logic [8:0] row,
                           input logic [1:0] exp, input string tag);
        repeat (w - 1) begin
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_act   = act;
        cmd_dev   = dev;
        cmd_bank  = bank;
        cmd_row   = row;
        @(posedge clk);
        #1;
        checks++;
        if (!(res_valid === 1'b1 && res_err === (exp != 2'd0) && res_reason === exp &&
              res_dev === dev && res_row === row)) begin
            errors++;
            $display("FAIL %s: got valid=%b err=%b reason=%0d dev=%0d row=%0d, expected valid=1 err=%b reason=%0d dev=%0d row=%0d",
                     tag, res_valid, res_err, res_reason, res_dev, res_row,
                     (exp != 2'd0), exp, dev, row);
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cfg_pkt_gap  = 8'd2;
        cfg_same_gap = 8'd6;
        cfg_bank_gap = 8'd4;
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_err !== 1'b0 || res_reason !== 2'd0) begin
            errors++;
            $display("FAIL R2: got valid=%b err=%b reason=%0d, expected 0 0 0",
                     res_valid, res_err, res_reason);
        end
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string t;
            t = (i == 8) ? "R9" : (i == 9) ? "R7" : (i == 14 || i == 17) ? "R8" : tag_of(TBL[i].rsn);
            run_cmd(int'(TBL[i].wait_c), TBL[i].act, TBL[i].dev, TBL[i].bank,
                    9'(i * 17 + 3), TBL[i].rsn, t);
        end

        // an idle cycle yields no result and no error pulse
        @(negedge clk);
        cmd_valid = 1'b0;
        @(posedge clk);
        #1;
        checks++;
        if (res_valid !== 1'b0 || res_err !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%b err=%b after idle, expected 0 0", res_valid, res_err);
        end

        // second configuration: packet 1, same kind 255, bank 3
        @(negedge clk);
        rst_n = 1'b0;
        cfg_pkt_gap  = 8'd1;
        cfg_same_gap = 8'd255;
        cfg_bank_gap = 8'd3;
        repeat (2) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_err !== 1'b0) begin
            errors++;
            $display("FAIL R2: got valid=%b err=%b in reset, expected 0 0", res_valid, res_err);
        end
        rst_n = 1'b1;

        run_cmd(1,   1'b1, 2'd3, 4'd8, 9'd100, 2'd0, "R2");  // history cleared
        run_cmd(1,   1'b0, 2'd1, 4'd0, 9'd101, 2'd0, "R2");  // new packet gap 1
        run_cmd(300, 1'b1, 2'd3, 4'd8, 9'd102, 2'd0, "R8");  // saturated, no wrap
        run_cmd(254, 1'b1, 2'd3, 4'd9, 9'd103, 2'd3, "R4");  // 254 < 255

        @(negedge clk);
        cmd_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule